// File: doc/BRIEF.md
# Bit-Band Alias Address Translator

This block sits between a bus master and a simple single-cycle memory or peripheral port. It looks at each master address. Two address windows, each 32 MB, are alias windows. Every word in an alias window stands for one bit of a 1 MB target region. One window covers an SRAM target and the other covers a peripheral target. Each target base and each window base is a parameter. Any other address goes straight through the block in the same cycle.

A read of an alias word returns the selected target bit in bit 0, and all other bits read as zero. A write to an alias word becomes an indivisible read-modify-write of the target word. The block fetches the target word in a first cycle, then writes it back in the next cycle with only the selected bit changed. A lock output stays high across both cycles so that no other agent can use the bus between them. The master sees busy during the fetch cycle, and the access completes at the end of the write-back cycle.

Top module: `bitband_xlate`

## Requirements
- R1: An address A in the SRAM alias window (default 0x2200_0000 to 0x23FF_FFFC) maps to target word address SRAM target base (default 0x2000_0000) + A[24:7]·4. The bit within that word is A[6:2], where A[4:2] gives the bit in the byte and A[6:5] gives the byte lane.
- R2: An address in the peripheral alias window (default 0x4200_0000 to 0x43FF_FFFC) maps the same way onto the peripheral target base (default 0x4000_0000).
- R3: An alias read completes in one cycle with busy low and lock low. The result carries the selected target bit in bit 0 and zeros in bits 31:1.
- R4: An alias write takes two cycles. In the first cycle the block issues a downstream read of the target word, with busy high and lock high. In the second cycle it issues a downstream write to the same address, with lock high and busy low. After the write, only the selected bit of the target word can differ.
- R5: On an alias write the selected bit takes the value of write-data bit 0. Write-data bits 31:1 have no effect.
- R6: Byte (size 00), halfword (01) and word (10) alias transfers behave the same way. The downstream size of every alias access is word (10).
- R7: An address outside both alias windows passes through in the same cycle. Address, write flag, write data and size are unchanged, the read data comes back raw, and busy and lock stay low. This includes the addresses just below and just above a window.
- R8: While reset is asserted and after reset, with no request, no downstream request is made and both lock and busy are low.
- R9: In the write-back cycle, the master's address and data are ignored. The write uses the address, bit and value captured in the fetch cycle.
- R10: Lock falls in the cycle after the write-back, so a locked pair never spans more than two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mReq | input | 1 | Master request |
| mWrite | input | 1 | Master write (1) or read (0) |
| mAddr | input | 32 | Master byte address |
| mSize | input | 2 | Transfer size: 00 byte, 01 halfword, 10 word |
| mWdata | input | 32 | Master write data |
| mRdata | output | 32 | Read data to master |
| mBusy | output | 1 | Master must hold the request this cycle |
| sReq | output | 1 | Downstream request |
| sWrite | output | 1 | Downstream write |
| sAddr | output | 32 | Downstream byte address |
| sSize | output | 2 | Downstream size |
| sWdata | output | 32 | Downstream write data |
| sRdata | input | 32 | Downstream read data, valid in the same cycle |
| sLock | output | 1 | Downstream bus lock |

## Verification
The hardest case to reach is a master that changes its address and data while the write-back cycle is in flight. A well-behaved master never does this, so it can only be seen by forcing it. The bench therefore waits for the fetch cycle, then drives a different alias address and the opposite data value in the write-back cycle. It confirms that the captured word is the one written and that the word the new address points at is left untouched. It also tests the last word of a window and the addresses on either side of the window edges, to catch off-by-one window decoding.

// File: rtl/bitband_pkg.sv
package bitband_pkg;
  typedef struct packed {
    logic capture;
    logic wrPhase;
  } bbStrobe_t;

  localparam logic [1:0] SIZE_WORD = 2'b10;
endpackage

// File: rtl/bitband_ctrl.sv
module bitband_ctrl
  import bitband_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      mReq,
  input  logic      mWrite,
  input  logic      isAlias,
  output bbStrobe_t strobe,
  output logic      lockOut,
  output logic      busyOut
);
  typedef enum logic {ST_IDLE, ST_WRITE} ctrlState_e;
  ctrlState_e state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: if (mReq && mWrite && isAlias) begin
        strobe.capture = 1'b1;
        stateNext      = ST_WRITE;
      end
      ST_WRITE: begin
        strobe.wrPhase = 1'b1;
        stateNext      = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;

  assign busyOut = strobe.capture;
  assign lockOut = strobe.capture | strobe.wrPhase;

  AST_FETCH_THEN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> strobe.wrPhase && lockOut && !busyOut); // R4
  AST_LOCK_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrPhase |=> !strobe.wrPhase); // R10
  AST_LOCK_HELD_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrPhase |-> lockOut && $past(lockOut)); // R4
endmodule

// File: rtl/bitband_dp.sv
module bitband_dp
  import bitband_pkg::*;
#(
  parameter logic [31:0] SRAM_TGT_BASE   = 32'h2000_0000,
  parameter logic [31:0] SRAM_ALIAS_BASE = 32'h2200_0000,
  parameter logic [31:0] PERI_TGT_BASE   = 32'h4000_0000,
  parameter logic [31:0] PERI_ALIAS_BASE = 32'h4200_0000,
  parameter int          TGT_BITS        = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  bbStrobe_t   strobe,
  input  logic        mReq,
  input  logic        mWrite,
  input  logic [31:0] mAddr,
  input  logic [1:0]  mSize,
  input  logic [31:0] mWdata,
  output logic [31:0] mRdata,
  output logic        isAlias,
  output logic        sReq,
  output logic        sWrite,
  output logic [31:0] sAddr,
  output logic [1:0]  sSize,
  output logic [31:0] sWdata,
  input  logic [31:0] sRdata
);
  localparam int ALIAS_BITS = TGT_BITS + 5;

  logic        hitSram, hitPeri;
  logic [31:0] tgtBase, tgtAddr;
  logic [4:0]  bitSel;
  logic [31:0] heldAddr, heldWord, mergedWord;
  logic [4:0]  heldBit;
  logic        heldVal;

  assign hitSram = mAddr[31:ALIAS_BITS] == SRAM_ALIAS_BASE[31:ALIAS_BITS];
  assign hitPeri = mAddr[31:ALIAS_BITS] == PERI_ALIAS_BASE[31:ALIAS_BITS];
  assign isAlias = hitSram | hitPeri;
  assign tgtBase = hitPeri ? PERI_TGT_BASE : SRAM_TGT_BASE;
  assign tgtAddr = {tgtBase[31:TGT_BITS], mAddr[ALIAS_BITS-1:7], 2'b00};
  assign bitSel  = mAddr[6:2];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      heldAddr <= '0;
      heldWord <= '0;
      heldBit  <= '0;
      heldVal  <= 1'b0;
    end else if (strobe.capture) begin
      heldAddr <= tgtAddr;
      heldWord <= sRdata;
      heldBit  <= bitSel;
      heldVal  <= mWdata[0];
    end

  always_comb begin
    mergedWord          = heldWord;
    mergedWord[heldBit] = heldVal;
  end

  always_comb begin
    if (strobe.wrPhase) begin
      sReq = 1'b1; sWrite = 1'b1; sAddr = heldAddr;
      sSize = SIZE_WORD; sWdata = mergedWord; mRdata = '0;
    end else if (mReq && isAlias) begin
      sReq = 1'b1; sWrite = 1'b0; sAddr = tgtAddr;
      sSize = SIZE_WORD; sWdata = '0;
      mRdata = {31'b0, sRdata[bitSel]};
    end else begin
      sReq = mReq; sWrite = mWrite; sAddr = mAddr;
      sSize = mSize; sWdata = mWdata; mRdata = sRdata;
    end
  end

  AST_WRITE_SAME_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrPhase |-> $past(sReq && !sWrite) && sAddr == $past(sAddr)); // R9
  AST_ONE_BIT_CHANGED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrPhase |-> $countones(sWdata ^ $past(sRdata)) <= 1); // R4
  AST_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (mReq && !mWrite && isAlias && !strobe.wrPhase) |-> mRdata[31:1] == '0); // R3
  AST_ALIAS_WORD_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    (sReq && (isAlias || strobe.wrPhase)) |-> sSize == SIZE_WORD); // R6
endmodule

// File: rtl/bitband_xlate.sv
module bitband_xlate
  import bitband_pkg::*;
#(
  parameter logic [31:0] SRAM_TGT_BASE   = 32'h2000_0000,
  parameter logic [31:0] SRAM_ALIAS_BASE = 32'h2200_0000,
  parameter logic [31:0] PERI_TGT_BASE   = 32'h4000_0000,
  parameter logic [31:0] PERI_ALIAS_BASE = 32'h4200_0000,
  parameter int          TGT_BITS        = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        mReq,
  input  logic        mWrite,
  input  logic [31:0] mAddr,
  input  logic [1:0]  mSize,
  input  logic [31:0] mWdata,
  output logic [31:0] mRdata,
  output logic        mBusy,
  output logic        sReq,
  output logic        sWrite,
  output logic [31:0] sAddr,
  output logic [1:0]  sSize,
  output logic [31:0] sWdata,
  input  logic [31:0] sRdata,
  output logic        sLock
);
  bbStrobe_t strobe;
  logic      isAlias;

  bitband_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .mReq(mReq), .mWrite(mWrite), .isAlias(isAlias),
    .strobe(strobe), .lockOut(sLock), .busyOut(mBusy)
  );

  bitband_dp #(
    .SRAM_TGT_BASE(SRAM_TGT_BASE), .SRAM_ALIAS_BASE(SRAM_ALIAS_BASE),
    .PERI_TGT_BASE(PERI_TGT_BASE), .PERI_ALIAS_BASE(PERI_ALIAS_BASE),
    .TGT_BITS(TGT_BITS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mReq(mReq), .mWrite(mWrite),
    .mAddr(mAddr), .mSize(mSize), .mWdata(mWdata), .mRdata(mRdata),
    .isAlias(isAlias), .sReq(sReq), .sWrite(sWrite), .sAddr(sAddr),
    .sSize(sSize), .sWdata(sWdata), .sRdata(sRdata)
  );

  AST_PASS_NO_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (mReq && !isAlias && !$past(mBusy)) |-> !sLock && !mBusy); // R7
endmodule

// File: tb/bitband_xlate_tb_top.sv
`timescale 1ns/1ps
module bitband_xlate_tb_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic mReq = 1'b0, mWrite = 1'b0;
  logic [31:0] mAddr = '0, mWdata = '0;
  logic [1:0]  mSize = 2'b10;
  logic [31:0] mRdata, sAddr, sWdata, sRdata;
  logic mBusy, sReq, sWrite, sLock;
  logic [1:0] sSize;
  int checks = 0, fails = 0;
  logic [31:0] tbMem  [2][64];
  logic [31:0] shadow [2][64];

  always #2 clk = ~clk;

  bitband_xlate dut_i (
    .clk(clk), .rstN(rstN), .mReq(mReq), .mWrite(mWrite), .mAddr(mAddr),
    .mSize(mSize), .mWdata(mWdata), .mRdata(mRdata), .mBusy(mBusy),
    .sReq(sReq), .sWrite(sWrite), .sAddr(sAddr), .sSize(sSize),
    .sWdata(sWdata), .sRdata(sRdata), .sLock(sLock)
  );

  function automatic logic [31:0] initWord(int r, int w);
    return 32'h1357_9BDF ^ (w * 32'h0101_0101) ^ (r * 32'h8000_0001);
  endfunction

  always @(posedge clk)
    if (!rstN) begin
      for (int r = 0; r < 2; r++) for (int w = 0; w < 64; w++) tbMem[r][w] <= initWord(r, w);
    end else if (sReq && sWrite) tbMem[sAddr[30]][sAddr[7:2]] <= sWdata;
  assign sRdata = tbMem[sAddr[30]][sAddr[7:2]];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit isAliasAddr(logic [31:0] a);
    return a[31:25] == 7'h11 || a[31:25] == 7'h21;
  endfunction
  function automatic logic [31:0] tgtOf(logic [31:0] a);
    return {(a[30] ? 12'h400 : 12'h200), a[24:7], 2'b00};
  endfunction

  task automatic aliasRead(input logic [31:0] a, input logic [1:0] sz, input string req);
    logic [31:0] expW;
    @(negedge clk);
    mReq = 1; mWrite = 0; mAddr = a; mSize = sz; mWdata = 32'hFFFF_FFFF;
    #1;
    expW = {31'b0, shadow[a[30]][a[12:7]][a[6:2]]};
    chk(sAddr == tgtOf(a) && !sWrite && sReq, req, sAddr, tgtOf(a));
    chk(mRdata == expW && !mBusy && !sLock && sSize == 2'b10, {req, "/R3/R6"}, mRdata, expW);
    @(negedge clk); mReq = 0;
  endtask

  task automatic aliasWrite(input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz,
                            input bit disturb, input string req);
    int r, w;
    r = a[30]; w = a[12:7];
    @(negedge clk);
    mReq = 1; mWrite = 1; mAddr = a; mSize = sz; mWdata = d;
    #1;
    chk(mBusy && sLock && sReq && !sWrite && sAddr == tgtOf(a), {req, "/R4 fetch"}, sAddr, tgtOf(a));
    @(negedge clk);
    if (disturb) begin mAddr = a ^ 32'h0000_0080; mWdata = ~d; end
    #1;
    chk(!mBusy && sLock && sWrite && sAddr == tgtOf(a) && sSize == 2'b10,
        {req, "/R4 writeback"}, sAddr, tgtOf(a));
    shadow[r][w][a[6:2]] = d[0];
    @(negedge clk); mReq = 0; #1;
    chk(!sLock && !mBusy, "R10 lock released", {31'b0, sLock}, 32'h0);
    chk(tbMem[r][w] == shadow[r][w], {req, "/R5 target word"}, tbMem[r][w], shadow[r][w]);
  endtask

  task automatic passAccess(input bit wr, input logic [31:0] a, input logic [31:0] d,
                            input logic [1:0] sz);
    @(negedge clk);
    mReq = 1; mWrite = wr; mAddr = a; mSize = sz; mWdata = d;
    #1;
    chk(sAddr == a && sWrite == wr && sWdata == d && sSize == sz && sReq, "R7 pass fields", sAddr, a);
    chk(!mBusy && !sLock, "R7 no busy/lock", {30'b0, mBusy, sLock}, 32'h0);
    if (!wr) chk(mRdata == tbMem[a[30]][a[7:2]], "R7 raw data", mRdata, tbMem[a[30]][a[7:2]]);
    @(negedge clk); mReq = 0;
    if (wr) begin
      shadow[a[30]][a[7:2]] = d;
      #1 chk(tbMem[a[30]][a[7:2]] == d, "R7 pass write", tbMem[a[30]][a[7:2]], d);
    end
  endtask

  // {write, addr, data, size}
  localparam logic [66:0] VEC [12] = '{
    {1'b0, 32'h2200_0080, 32'h0, 2'b10},
    {1'b1, 32'h2200_0080, 32'h0000_0001, 2'b10},
    {1'b0, 32'h2200_0080, 32'h0, 2'b10},
    {1'b1, 32'h2200_017C, 32'hFFFF_FFFE, 2'b10},
    {1'b0, 32'h2200_017C, 32'h0, 2'b00},
    {1'b1, 32'h4200_0194, 32'h0000_0001, 2'b00},
    {1'b0, 32'h4200_0194, 32'h0, 2'b01},
    {1'b1, 32'h4200_01A0, 32'h0000_0003, 2'b01},
    {1'b0, 32'h2000_0008, 32'h0, 2'b10},
    {1'b1, 32'h4000_000C, 32'hA5A5_0F0F, 2'b10},
    {1'b0, 32'h4000_000C, 32'h0, 2'b10},
    {1'b0, 32'h4200_01A0, 32'h0, 2'b10}
  };

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int r = 0; r < 2; r++) for (int w = 0; w < 64; w++) shadow[r][w] = initWord(r, w);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!sReq && !sLock && !mBusy, "R8 reset idle", {29'b0, sReq, sLock, mBusy}, 32'h0);
    rstN = 1;
    @(negedge clk); #1;
    chk(!sReq && !sLock && !mBusy, "R8 after reset", {29'b0, sReq, sLock, mBusy}, 32'h0);

    for (int i = 0; i < 12; i++) begin
      logic [31:0] a, d;
      a = VEC[i][65:34]; d = VEC[i][33:2];
      if (!isAliasAddr(a)) passAccess(VEC[i][66], a, d, VEC[i][1:0]);
      else if (VEC[i][66]) aliasWrite(a, d, VEC[i][1:0], 1'b0, a[30] ? "R2 map" : "R1 map");
      else aliasRead(a, VEC[i][1:0], a[30] ? "R2 map" : "R1 map");
    end

    // R5: upper data bits ignored, bit 0 clears
    aliasWrite(32'h2200_0284, 32'hFFFF_FFFE, 2'b10, 1'b0, "R5 bit0 only");
    // R9: master changes address and data during write-back
    aliasWrite(32'h2200_0308, 32'h0000_0001, 2'b10, 1'b1, "R9 held");
    chk(tbMem[0][7] == shadow[0][7], "R9 other word untouched", tbMem[0][7], shadow[0][7]);
    // Window edges
    aliasRead(32'h23FF_FFFC, 2'b10, "R1 last alias word");
    passAccess(1'b0, 32'h2400_0000, 32'h0, 2'b10);
    passAccess(1'b0, 32'h21FF_FFFC, 32'h0, 2'b01);
    passAccess(1'b0, 32'h4400_0004, 32'h0, 2'b00);
    aliasWrite(32'h4200_0000, 32'h0000_0000, 2'b00, 1'b0, "R2 first alias word");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule